// File: doc/BRIEF.md
# Chip-Select Framed Three-Mode Serial Port

This block is the host-facing serial port of a segment display driver. A microcontroller talks to it over three wires: a chip select, a serial clock and one bidirectional data line. The port only listens while chip select is high, so the clock and data lines can be shared with other devices. Each chip-select window belongs to one of three modes, and the falling chip-select edges step the port through them in a fixed cycle.

The first mode takes in a display frame. The port shifts in 37 bits: 34 segment bits followed by 3 factory test bits. It copies them to its output latches when chip select falls. The second mode drives the data line and shifts out a 12-bit snapshot of the key matrix. The third mode shifts out six 6-bit converter results. A window closed with no clock edge at all does not advance an output mode. Two such empty windows in a row send the port straight back to display input.

All three pins are resynchronised to the internal clock, and edges are found on the synchronised copies. The host must therefore hold each clock level and each data bit for several internal clock periods. The reset is asserted asynchronously and released synchronously.

Top module: `vfd_serial_port`

## Requirements
- R1: After reset the port is in display-input mode. `disp_word_o` and `test_bits_o` are all zero, and `sdio_oe_o` stays low even when chip select is high.
- R2: While chip select is low, clock and data activity does not change `disp_word_o` or `test_bits_o` and does not raise `sdio_oe_o`.
- R3: In display-input mode, data is sampled on each rising clock edge. Of the last 37 bits received, the first goes to `disp_word_o[33]` and the following bits go down to `disp_word_o[0]`. The final three bits go to `test_bits_o[2]`, `[1]` and `[0]`. The frame register clears when chip select rises, so a short frame leaves zeros in the upper positions.
- R4: `disp_word_o` and `test_bits_o` change only at the falling chip-select edge that ends a display window with at least one clock edge.
- R5: A display window with at least one clock edge is followed by keyscan-output mode. In that mode, `key_state_i` is captured when chip select rises. Key (row r, column c) sits at bit index (r-1)*4+(c-1). The bits are sent from bit 11 down to bit 0. The first bit is on `sdio_o` before any clock edge, and each rising clock edge moves to the next bit.
- R6: A clocked keyscan window is followed by A/D-output mode. `adc_result_i` holds channel k in bits [6k-1:6k-6]. It is captured at the rising chip-select edge and sent from bit 35 down to bit 0, and zeros follow the last bit.
- R7: A clocked A/D window is followed by display-input mode.
- R8: In an output mode, two consecutive chip-select windows with no clock edge return the port to display-input mode and leave the latched display word intact. A single empty window leaves the mode unchanged.
- R9: A display window with no clock edge neither latches nor changes the mode.
- R10: `sdio_oe_o` is high only while chip select is high in an output mode. `sdio_o` is 0 whenever `sdio_oe_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select from host, high = selected |
| sclk_i | input | 1 | Serial clock from host |
| sdio_i | input | 1 | Data pin input path |
| sdio_o | output | 1 | Data pin output path |
| sdio_oe_o | output | 1 | Data pin output enable |
| key_state_i | input | 12 | Key matrix state, 1 = pressed |
| adc_result_i | input | 36 | Six 6-bit conversion results |
| disp_word_o | output | 34 | Latched segment word |
| test_bits_o | output | 3 | Latched test bits |

## Verification
The hardest state to reach is the escape from an output mode on two empty chip-select windows. It has to be told apart from a single empty window, which must leave the mode alone. From the ports the mode can only be seen through the output enable while chip select is high. The stimulus therefore enters keyscan mode with a real frame and opens empty windows. After each window it opens another one and checks whether the data pin turns around. It then reads back the key and converter streams, including bits past the end of the converter stream.

// File: rtl/vfd_sp_pkg.sv
package vfd_sp_pkg;
  typedef enum logic [1:0] {
    PM_DISP = 2'd0,
    PM_KEY  = 2'd1,
    PM_ADC  = 2'd2
  } port_mode_e;
endpackage

// File: rtl/vfd_sp_sync.sv
// Multi-bit level synchroniser: each bit has its own flop chain.
module vfd_sp_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] lvl_o
);
  localparam int LAST = STAGES - 1;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    if (STAGES > 1) begin : g_multi
      assign chain_d = {chain_q[STAGES-2:0], async_i[b]};
    end else begin : g_single
      assign chain_d = async_i[b];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= chain_d;
    end

    assign lvl_o[b] = chain_q[LAST];
  end
endmodule

// File: rtl/vfd_sp_ctrl.sv
// Mode sequencer: CS edges step the mode, CLOCK edges gate shifting.
module vfd_sp_ctrl
  import vfd_sp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_lvl_i,
  input  logic       sclk_lvl_i,
  output port_mode_e mode_o,
  output logic       rx_clear_o,
  output logic       rx_shift_o,
  output logic       latch_en_o,
  output logic       tx_load_key_o,
  output logic       tx_load_adc_o,
  output logic       tx_shift_o,
  output logic       oe_o
);
  port_mode_e mode_q, mode_d;
  logic cs_prev_q, sclk_prev_q;
  logic saw_clk_q, saw_clk_d;
  logic empty_q, empty_d;
  logic cs_rise, cs_fall, clk_ok;

  assign cs_rise = cs_lvl_i & ~cs_prev_q;
  assign cs_fall = ~cs_lvl_i & cs_prev_q;
  assign clk_ok  = sclk_lvl_i & ~sclk_prev_q & cs_lvl_i;

  always_comb begin
    mode_d    = mode_q;
    saw_clk_d = saw_clk_q;
    empty_d   = empty_q;
    if (cs_rise)     saw_clk_d = 1'b0;
    else if (clk_ok) saw_clk_d = 1'b1;
    if (cs_fall) begin
      unique case (mode_q)
        PM_DISP: begin
          empty_d = 1'b0;
          if (saw_clk_q) mode_d = PM_KEY;
        end
        PM_KEY, PM_ADC: begin
          if (saw_clk_q) begin
            mode_d  = (mode_q == PM_KEY) ? PM_ADC : PM_DISP;
            empty_d = 1'b0;
          end else if (empty_q) begin
            mode_d  = PM_DISP;
            empty_d = 1'b0;
          end else begin
            empty_d = 1'b1;
          end
        end
        default: begin
          mode_d  = PM_DISP;
          empty_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= PM_DISP;
      cs_prev_q   <= 1'b0;
      sclk_prev_q <= 1'b0;
      saw_clk_q   <= 1'b0;
      empty_q     <= 1'b0;
    end else begin
      mode_q      <= mode_d;
      cs_prev_q   <= cs_lvl_i;
      sclk_prev_q <= sclk_lvl_i;
      saw_clk_q   <= saw_clk_d;
      empty_q     <= empty_d;
    end
  end

  assign mode_o        = mode_q;
  assign rx_clear_o    = cs_rise & (mode_q == PM_DISP);
  assign rx_shift_o    = clk_ok & (mode_q == PM_DISP);
  assign latch_en_o    = cs_fall & (mode_q == PM_DISP) & saw_clk_q;
  assign tx_load_key_o = cs_rise & (mode_q == PM_KEY);
  assign tx_load_adc_o = cs_rise & (mode_q == PM_ADC);
  assign tx_shift_o    = clk_ok & (mode_q != PM_DISP);
  assign oe_o          = cs_lvl_i & (mode_q != PM_DISP);
endmodule

// File: rtl/vfd_sp_rx.sv
// Display frame shift register and output latches.
module vfd_sp_rx #(
  parameter int DISP_W = 34,
  parameter int TEST_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              shift_i,
  input  logic              data_i,
  input  logic              latch_en_i,
  output logic [DISP_W-1:0] disp_o,
  output logic [TEST_W-1:0] test_o
);
  localparam int FRAME_W = DISP_W + TEST_W;

  logic [FRAME_W-1:0] sr_q, sr_d;
  logic [DISP_W-1:0]  disp_q, disp_d;
  logic [TEST_W-1:0]  test_q, test_d;

  always_comb begin
    sr_d   = sr_q;
    disp_d = disp_q;
    test_d = test_q;
    if (clear_i)      sr_d = '0;
    else if (shift_i) sr_d = {sr_q[FRAME_W-2:0], data_i};
    if (latch_en_i) begin
      disp_d = sr_q[FRAME_W-1:TEST_W];
      test_d = sr_q[TEST_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      disp_q <= '0;
      test_q <= '0;
    end else begin
      sr_q   <= sr_d;
      disp_q <= disp_d;
      test_q <= test_d;
    end
  end

  assign disp_o = disp_q;
  assign test_o = test_q;
endmodule

// File: rtl/vfd_sp_tx.sv
// Output shift register shared by the keyscan and A/D streams.
module vfd_sp_tx #(
  parameter int KEY_W = 12,
  parameter int ADC_W = 36
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_key_i,
  input  logic             load_adc_i,
  input  logic             shift_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic [ADC_W-1:0] adc_i,
  output logic             bit_o
);
  localparam int PAD_W = (ADC_W > KEY_W) ? ADC_W - KEY_W : 1;

  logic [ADC_W-1:0] sr_q, sr_d;
  logic [ADC_W-1:0] key_img;

  if (ADC_W > KEY_W) begin : g_pad
    assign key_img = {key_i, {PAD_W{1'b0}}};
  end else if (ADC_W == KEY_W) begin : g_same
    assign key_img = key_i;
  end else begin : g_trim
    assign key_img = key_i[KEY_W-1 -: ADC_W];
  end

  always_comb begin
    sr_d = sr_q;
    if (load_key_i)      sr_d = key_img;
    else if (load_adc_i) sr_d = adc_i;
    else if (shift_i)    sr_d = {sr_q[ADC_W-2:0], 1'b0};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= sr_d;
  end

  assign bit_o = sr_q[ADC_W-1];
endmodule

// File: rtl/vfd_serial_port.sv
module vfd_serial_port #(
  parameter int DISP_W      = 34,
  parameter int TEST_W      = 3,
  parameter int KEY_ROWS    = 3,
  parameter int KEY_COLS    = 4,
  parameter int ADC_CH      = 6,
  parameter int ADC_BITS    = 6,
  parameter int SYNC_STAGES = 2,
  localparam int KEY_W      = KEY_ROWS * KEY_COLS,
  localparam int ADC_W      = ADC_CH * ADC_BITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              sclk_i,
  input  logic              sdio_i,
  output logic              sdio_o,
  output logic              sdio_oe_o,
  input  logic [KEY_W-1:0]  key_state_i,
  input  logic [ADC_W-1:0]  adc_result_i,
  output logic [DISP_W-1:0] disp_word_o,
  output logic [TEST_W-1:0] test_bits_o
);
  import vfd_sp_pkg::*;

  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  logic [2:0] pin_lvl;
  logic       cs_lvl, sclk_lvl, data_lvl;
  port_mode_e mode;
  logic rx_clear, rx_shift, latch_en;
  logic tx_load_key, tx_load_adc, tx_shift, tx_bit, oe;

  // Reset: asserted at once, released two clocks later.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= 2'b00;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  vfd_sp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .async_i({sdio_i, sclk_i, cs_i}),
    .lvl_o  (pin_lvl)
  );
  assign cs_lvl   = pin_lvl[0];
  assign sclk_lvl = pin_lvl[1];
  assign data_lvl = pin_lvl[2];

  vfd_sp_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_sync_n),
    .cs_lvl_i     (cs_lvl),
    .sclk_lvl_i   (sclk_lvl),
    .mode_o       (mode),
    .rx_clear_o   (rx_clear),
    .rx_shift_o   (rx_shift),
    .latch_en_o   (latch_en),
    .tx_load_key_o(tx_load_key),
    .tx_load_adc_o(tx_load_adc),
    .tx_shift_o   (tx_shift),
    .oe_o         (oe)
  );

  vfd_sp_rx #(.DISP_W(DISP_W), .TEST_W(TEST_W)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .clear_i   (rx_clear),
    .shift_i   (rx_shift),
    .data_i    (data_lvl),
    .latch_en_i(latch_en),
    .disp_o    (disp_word_o),
    .test_o    (test_bits_o)
  );

  vfd_sp_tx #(.KEY_W(KEY_W), .ADC_W(ADC_W)) u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .load_key_i(tx_load_key),
    .load_adc_i(tx_load_adc),
    .shift_i   (tx_shift),
    .key_i     (key_state_i),
    .adc_i     (adc_result_i),
    .bit_o     (tx_bit)
  );

  assign sdio_oe_o = oe;
  assign sdio_o    = oe & tx_bit;
endmodule

// File: rtl/vfd_serial_port_chk.sv
module vfd_serial_port_chk
  import vfd_sp_pkg::*;
#(
  parameter int DISP_W = 34,
  parameter int TEST_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_lvl,
  input port_mode_e        mode,
  input logic              latch_en,
  input logic              tx_bit,
  input logic              sdio_oe_o,
  input logic [DISP_W-1:0] disp_word_o,
  input logic [TEST_W-1:0] test_bits_o
);
  // R4
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_en |=> ($stable(disp_word_o) && $stable(test_bits_o)));

  // R2
  tx_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_lvl |=> $stable(tx_bit));

  // R10
  oe_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdio_oe_o |-> cs_lvl);

  // R9
  latch_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_en |-> (mode == PM_DISP));

  // R5
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_lvl |=> $stable(mode));

  // R7
  adc_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == PM_ADC) |=> (mode != PM_KEY));

  // R6
  disp_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == PM_DISP) |=> (mode != PM_ADC));
endmodule

bind vfd_serial_port vfd_serial_port_chk #(.DISP_W(DISP_W), .TEST_W(TEST_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_lvl     (cs_lvl),
  .mode       (mode),
  .latch_en   (latch_en),
  .tx_bit     (tx_bit),
  .sdio_oe_o  (sdio_oe_o),
  .disp_word_o(disp_word_o),
  .test_bits_o(test_bits_o)
);

// File: tb/vfd_serial_port_tb.sv
module vfd_serial_port_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic sdo, oe;
  logic [11:0] key_st = '0;
  logic [35:0] adc = '0;
  logic [33:0] disp;
  logic [2:0]  tbits;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vfd_serial_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sclk_i(sclk), .sdio_i(sdi),
    .sdio_o(sdo), .sdio_oe_o(oe), .key_state_i(key_st), .adc_result_i(adc),
    .disp_word_o(disp), .test_bits_o(tbits)
  );

  // {display 34, test 3, key 12, adc 36}
  localparam logic [84:0] VEC [4] = '{
    {34'h3_FFFF_FFFF, 3'b000, 12'hFFF, 36'hF_FFFF_FFFF},
    {34'h0_0000_0001, 3'b101, 12'h001, 36'h0_0000_0001},
    {34'h2_DEAD_BEEF, 3'b000, 12'hA5C, 36'h8_1234_5678},
    {34'h1_5555_AAAA, 3'b011, 12'h800, 36'h6_9C3A_0F5E}
  };

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cs_open();
    cs = 1'b1;
    wait_clk(12);
  endtask

  task automatic cs_close();
    sclk = 1'b0;
    cs = 1'b0;
    wait_clk(12);
  endtask

  task automatic send_bits(logic [63:0] v, int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = v[i];
      wait_clk(6);
      sclk = 1'b1;
      wait_clk(8);
      sclk = 1'b0;
      wait_clk(6);
    end
  endtask

  task automatic read_bits(int n, output logic [63:0] got);
    got = '0;
    for (int i = 0; i < n; i++) begin
      got = {got[62:0], sdo};
      sclk = 1'b1;
      wait_clk(8);
      sclk = 1'b0;
      wait_clk(8);
    end
  endtask

  function automatic logic [36:0] model(logic [63:0] v, int n);
    logic [36:0] sr = '0;
    for (int i = n - 1; i >= 0; i--) sr = {sr[35:0], v[i]};
    return sr;
  endfunction

  initial begin
    logic [63:0] got;
    logic [36:0] fr;
    logic [84:0] v;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    // R1 reset state
    check("R1 disp after reset", disp, 0);
    check("R1 test after reset", tbits, 0);
    check("R10 sdio_o idle", sdo, 0);
    cs_open();
    check("R1 display mode oe low", oe, 0);
    cs_close();

    // Table walk: display frame, key read, A/D read
    for (int i = 0; i < 4; i++) begin
      v = VEC[i];
      key_st = v[47:36];
      adc = v[35:0];
      cs_open();
      send_bits({27'b0, v[84:48]}, 37);
      cs_close();
      check("R3 display word", disp, v[84:51]);
      check("R3 test bits", tbits, v[50:48]);
      cs_open();
      check("R10 oe in key window", oe, 1);
      read_bits(12, got);
      cs_close();
      check("R5 key stream", got, v[47:36]);
      cs_open();
      read_bits(36, got);
      cs_close();
      check("R6 adc stream", got, v[35:0]);
    end
    // Back in display mode (R7)
    cs_open();
    check("R7 display mode after adc", oe, 0);
    cs_close();
    // R9: that empty window did not latch
    check("R9 empty window keeps word", disp, VEC[3][84:51]);

    // R2: clock and data while CS low
    for (int i = 0; i < 20; i++) begin
      sdi = i[0];
      sclk = ~sclk;
      wait_clk(8);
    end
    sclk = 1'b0;
    wait_clk(8);
    check("R2 disp with cs low", disp, VEC[3][84:51]);
    check("R2 oe with cs low", oe, 0);

    // R3: over-length frame keeps last 37 bits
    cs_open();
    send_bits(64'h00_00AB_CDEF_1234_5, 40);
    cs_close();
    fr = model(64'h00_00AB_CDEF_1234_5, 40);
    check("R3 long frame word", disp, fr[36:3]);
    check("R4 long frame test", tbits, fr[2:0]);

    // R8: two empty windows in keyscan mode -> display
    cs_open(); cs_close();
    check("R8 one empty window", disp, fr[36:3]);
    cs_open(); cs_close();
    cs_open();
    check("R8 two empty windows -> display", oe, 0);
    send_bits(64'h15, 5);
    cs_close();
    fr = model(64'h15, 5);
    check("R3 short frame word", disp, fr[36:3]);
    check("R3 short frame test", tbits, fr[2:0]);

    // R8: single empty window keeps keyscan mode
    key_st = 12'h3C9;
    adc = 36'hA_BCDE_F012;
    cs_open(); cs_close();
    cs_open();
    check("R8 single empty keeps key mode", oe, 1);
    read_bits(12, got);
    cs_close();
    check("R5 key after empty window", got, 64'h3C9);
    cs_open();
    read_bits(38, got);
    cs_close();
    check("R6 adc over-read", got, {26'b0, 36'hA_BCDE_F012, 2'b00});

    // Now display mode; enter key mode then reset mid-window
    cs_open();
    send_bits(64'h1, 37);
    cs_close();
    cs_open();
    check("R5 key mode oe", oe, 1);
    rst_n = 1'b0;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(12);
    check("R1 oe after reset", oe, 0);
    check("R1 disp after reset", disp, 0);
    cs_close();
    check("R4 empty window after reset", disp, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=150000 cycles expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule